// File: doc/BRIEF.md
# Watchdog Mode Register and Timeout Pulse Controller

This block sits beside a watchdog down-counter. It keeps the watchdog's mode word behind a 12-bit access key and turns the counter's single-cycle "reached zero" strobe into two stretched outputs: an interrupt request and a system reset request. Each output has its own enable and its own length code. The length is a power of two, counted in bus clock cycles. A master enable gates both outputs.

Software reaches the mode word through a plain write strobe with a 24-bit data word and a combinational read-back word. A write changes the register only when its top twelve bits carry the key value 0xABC. A zero strobe loads a per-output cycle counter with the length configured at that moment. The output stays high while its counter is non-zero and the master enable is set.

Top module: `wdt_mode_ctrl`

## Requirements
- R1: A write (wr_en high) updates the mode word only when wr_data[23:12] equals 0xABC. With any other key the read-back word is unchanged in the next cycle.
- R2: rd_data[23:12] always reads as zero, whatever was written.
- R3: Reserved bits 11:9 and 3 are not stored and always read as zero. An accepted write stores wr_data & 0x1F7.
- R4: The interrupt length code in bits 8:7 gives an active time of 4 << code bus cycles (4, 8, 16, 32).
- R5: The reset length code in bits 6:4 gives an active time of 2 << code bus cycles (2 up to 256). No reset pulse is shorter than 2 cycles.
- R6: A zero strobe starts an interrupt pulse only if bit 2 (interrupt enable) and bit 0 (master enable) are both set.
- R7: A zero strobe starts a reset pulse only if bit 1 (reset enable) and bit 0 (master enable) are both set.
- R8: While bit 0 is clear, both outputs are low. Clearing it during a pulse drops both outputs in the same cycle that the register changes.
- R9: After reset the mode word reads 0x0001C2 (interrupt code 3, reset code 4, reset enable set, other enables clear) and both outputs are low.
- R10: A zero strobe that arrives while a pulse is active restarts that pulse at its full configured length.
- R11: A pulse keeps the length configured at the cycle of its zero strobe. Later writes to the length fields do not change it.
- R12: An output rises in the cycle after the zero strobe is sampled and stays high for exactly its configured length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the mode word |
| wr_data | input | 24 | Write data; bits 23:12 carry the access key |
| rd_data | output | 24 | Current mode word, with key and reserved bits reading as zero |
| zero_evt | input | 1 | Single-cycle strobe from the down-counter reaching zero |
| irq_req | output | 1 | Stretched interrupt request |
| sysrst_req | output | 1 | Stretched system reset request |

## Verification
The bound assertions check these rules on every cycle: the key guard, the zero read-back of the key and reserved fields, silent outputs while the master enable is clear, that each output rises only after a qualified zero strobe, and the two-cycle minimum on the reset pulse. The exact pulse lengths for every code, the restart of a pulse by a second strobe, and a pulse keeping its length after a later write all span many cycles. Only the bench's scenarios show these, with the cycle model in the bench compared on every clock.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
   // Field positions are fixed by the mode word layout that software decodes.
   localparam int WDM_DATA_W      = 24;
   localparam int WDM_KEY_LSB     = 12;
   localparam int WDM_KEY_W       = 12;
   localparam logic [11:0] WDM_KEY_VALUE = 12'hABC;
   localparam int WDM_IRQ_LEN_LSB = 7;
   localparam int WDM_IRQ_LEN_W   = 2;
   localparam int WDM_RST_LEN_LSB = 4;
   localparam int WDM_RST_LEN_W   = 3;
   localparam int WDM_IRQ_EN_BIT  = 2;
   localparam int WDM_RST_EN_BIT  = 1;
   localparam int WDM_WD_EN_BIT   = 0;
   localparam logic [23:0] WDM_STORE_MASK = 24'h0001F7;
   localparam logic [23:0] WDM_RESET_WORD = 24'h0001C2;
   // Shortest pulse of each output, as a power of two.
   localparam int WDM_IRQ_MIN_LOG2 = 2;
   localparam int WDM_RST_MIN_LOG2 = 1;

   typedef struct packed {
      logic [WDM_IRQ_LEN_W-1:0] irq_len;
      logic [WDM_RST_LEN_W-1:0] rst_len;
      logic                     irq_en;
      logic                     rst_en;
      logic                     wd_en;
   } wdm_mode_t;
endpackage

// File: rtl/wdm_mode_reg.sv
module wdm_mode_reg #(
   parameter int DATA_W = 24,
   parameter int KEY_LSB = 12,
   parameter int KEY_W = 12,
   parameter logic [KEY_W-1:0] KEY_VALUE = 12'hABC,
   parameter logic [DATA_W-1:0] STORE_MASK = 24'h0001F7,
   parameter logic [DATA_W-1:0] RESET_WORD = 24'h0001C2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] mode_q
);
   localparam int KEY_MSB = KEY_LSB + KEY_W - 1;
   localparam logic [DATA_W-1:0] KEY_FIELD = ((DATA_W)'(1) << KEY_W) - 1;

   if (KEY_MSB >= DATA_W) begin : g_bad_key
      $error("wdm_mode_reg: key field exceeds data width");
   end
   if (((KEY_FIELD << KEY_LSB) & STORE_MASK) != '0) begin : g_bad_mask
      $error("wdm_mode_reg: stored bits overlap the key field");
   end
   if ((RESET_WORD & ~STORE_MASK) != '0) begin : g_bad_reset
      $error("wdm_mode_reg: reset word sets unstored bits");
   end

   logic key_ok;
   logic [DATA_W-1:0] stored;
   logic unused_wr_bits;

   assign key_ok = (wr_data[KEY_MSB:KEY_LSB] == KEY_VALUE);
   assign unused_wr_bits = ^(wr_data & ~STORE_MASK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stored <= RESET_WORD;
      end else if (wr_en && key_ok) begin
         stored <= wr_data & STORE_MASK;
      end
   end

   // Key and reserved positions read as zero; the mask keeps them constant.
   assign mode_q = stored & STORE_MASK;
endmodule

// File: rtl/wdm_pulse_timer.sv
module wdm_pulse_timer #(
   parameter int CODE_W = 2,
   parameter int MIN_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic              abort,
   input  logic [CODE_W-1:0] len_code,
   output logic              active
);
   localparam int MAX_LOG2 = MIN_LOG2 + (1 << CODE_W) - 1;
   localparam int CNT_W = MAX_LOG2 + 1;

   if (MIN_LOG2 < 1) begin : g_bad_min
      $error("wdm_pulse_timer: a pulse must last at least two cycles");
   end
   if (CODE_W < 1 || CODE_W > 4) begin : g_bad_code
      $error("wdm_pulse_timer: length code width out of range");
   end

   logic [CNT_W-1:0] len_val;
   logic [CNT_W-1:0] remain;

   always_comb begin
      len_val = (CNT_W)'(1) << (MIN_LOG2 + int'(len_code));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (abort) begin
         remain <= '0;
      end else if (fire) begin
         remain <= len_val;
      end else if (remain != '0) begin
         remain <= remain - 1'b1;
      end
   end

   assign active = (remain != '0) && !abort;
endmodule

// File: rtl/wdt_mode_ctrl.sv
module wdt_mode_ctrl
   import wdm_pkg::*;
#(
   parameter int DATA_W = WDM_DATA_W,
   parameter int IRQ_MIN_LOG2 = WDM_IRQ_MIN_LOG2,
   parameter int RST_MIN_LOG2 = WDM_RST_MIN_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              zero_evt,
   output logic              irq_req,
   output logic              sysrst_req
);
   if (DATA_W != WDM_DATA_W) begin : g_bad_width
      $error("wdt_mode_ctrl: data width must match the mode word layout");
   end

   logic [DATA_W-1:0] mode_word;
   wdm_mode_t mode;

   wdm_mode_reg #(
      .DATA_W(DATA_W),
      .KEY_LSB(WDM_KEY_LSB),
      .KEY_W(WDM_KEY_W),
      .KEY_VALUE(WDM_KEY_VALUE),
      .STORE_MASK(WDM_STORE_MASK),
      .RESET_WORD(WDM_RESET_WORD)
   ) u_mode (
      .clk(clk),
      .rst_n(rst_n),
      .wr_en(wr_en),
      .wr_data(wr_data),
      .mode_q(mode_word)
   );

   always_comb begin
      mode.irq_len = mode_word[WDM_IRQ_LEN_LSB +: WDM_IRQ_LEN_W];
      mode.rst_len = mode_word[WDM_RST_LEN_LSB +: WDM_RST_LEN_W];
      mode.irq_en  = mode_word[WDM_IRQ_EN_BIT];
      mode.rst_en  = mode_word[WDM_RST_EN_BIT];
      mode.wd_en   = mode_word[WDM_WD_EN_BIT];
   end

   logic stop_all;
   logic irq_fire;
   logic rst_fire;

   assign stop_all = !mode.wd_en;
   assign irq_fire = zero_evt && mode.wd_en && mode.irq_en;
   assign rst_fire = zero_evt && mode.wd_en && mode.rst_en;

   wdm_pulse_timer #(
      .CODE_W(WDM_IRQ_LEN_W),
      .MIN_LOG2(IRQ_MIN_LOG2)
   ) u_irq_timer (
      .clk(clk),
      .rst_n(rst_n),
      .fire(irq_fire),
      .abort(stop_all),
      .len_code(mode.irq_len),
      .active(irq_req)
   );

   wdm_pulse_timer #(
      .CODE_W(WDM_RST_LEN_W),
      .MIN_LOG2(RST_MIN_LOG2)
   ) u_rst_timer (
      .clk(clk),
      .rst_n(rst_n),
      .fire(rst_fire),
      .abort(stop_all),
      .len_code(mode.rst_len),
      .active(sysrst_req)
   );

   assign rd_data = mode_word;
endmodule

// File: rtl/wdt_mode_ctrl_chk.sv
module wdt_mode_ctrl_chk
   import wdm_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [23:0] wr_data,
   input logic [23:0] rd_data,
   input logic        zero_evt,
   input logic        irq_req,
   input logic        sysrst_req
);
   p_key_guard_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[23:12] != WDM_KEY_VALUE) |=> $stable(rd_data));

   p_key_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[23:12] == WDM_KEY_VALUE) |=> (rd_data == ($past(wr_data) & 24'h0001F7)));

   p_key_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[23:12] == 12'h000);

   p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[11:9] == 3'b000) && !rd_data[3]);

   p_master_off_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[0] |-> (!irq_req && !sysrst_req));

   p_irq_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> ($past(zero_evt) && $past(rd_data[2]) && $past(rd_data[0])));

   p_rst_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sysrst_req) |-> ($past(zero_evt) && $past(rd_data[1]) && $past(rd_data[0])));

   p_rst_min_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sysrst_req) && rd_data[0]) |-> $past(sysrst_req, 2));
endmodule

bind wdt_mode_ctrl wdt_mode_ctrl_chk u_chk (
   .clk(clk),
   .rst_n(rst_n),
   .wr_en(wr_en),
   .wr_data(wr_data),
   .rd_data(rd_data),
   .zero_evt(zero_evt),
   .irq_req(irq_req),
   .sysrst_req(sysrst_req)
);

// File: tb/sim_wdt_mode_ctrl.sv
module sim_wdt_mode_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [23:0] wr_data = '0;
   logic [23:0] rd_data;
   logic        zero_evt = 1'b0;
   logic        irq_req;
   logic        sysrst_req;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // Reference model state
   int m_mode = 'h1C2;
   int m_irq_left = 0;
   int m_rst_left = 0;

   always #10 clk = ~clk;

   wdt_mode_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .zero_evt(zero_evt), .irq_req(irq_req),
      .sysrst_req(sysrst_req)
   );

   task automatic check(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, actual, expected, $time);
      end
   endtask

   // Behavioural model of the requirements, advanced on each rising edge.
   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 'h1C2;
         m_irq_left = 0;
         m_rst_left = 0;
      end else begin
         int old;
         old = m_mode;
         if ((old & 1) == 0) begin
            m_irq_left = 0;
            m_rst_left = 0;
         end else begin
            if (zero_evt && (old & 4) != 0) m_irq_left = 4 << ((old >> 7) & 3);
            else if (m_irq_left > 0) m_irq_left--;
            if (zero_evt && (old & 2) != 0) m_rst_left = 2 << ((old >> 4) & 7);
            else if (m_rst_left > 0) m_rst_left--;
         end
         if (wr_en && wr_data[23:12] == 12'hABC) m_mode = int'(wr_data) & 'h1F7;
      end
   end

   // Every-cycle comparison against the model, away from the rising edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R1 R3 mode word", int'(rd_data), m_mode);
         check("R4 R6 R10 R11 irq", int'(irq_req), int'(m_irq_left > 0 && (m_mode & 1) != 0));
         check("R5 R7 R8 R12 rst", int'(sysrst_req), int'(m_rst_left > 0 && (m_mode & 1) != 0));
      end
   end

   task automatic write_mode(input logic [23:0] d);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      wr_data = '0;
   endtask

   task automatic measure(output int n_irq, output int n_rst);
      zero_evt = 1'b1;
      @(negedge clk);
      zero_evt = 1'b0;
      n_irq = 0;
      n_rst = 0;
      for (int c = 0; c < 400; c++) begin
         if (!irq_req && !sysrst_req) break;
         if (irq_req) n_irq++;
         if (sysrst_req) n_rst++;
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      int ni;
      int nr;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      check("R9 reset word", int'(rd_data), 'h1C2);
      check("R9 irq low", int'(irq_req), 0);
      check("R9 rst low", int'(sysrst_req), 0);

      // R1: wrong key leaves the word alone
      write_mode(24'h123FFF);
      check("R1 bad key", int'(rd_data), 'h1C2);
      write_mode(24'hABB007);
      check("R1 near key", int'(rd_data), 'h1C2);

      // R2 R3: key and reserved bits read zero
      write_mode(24'hABCFFF);
      check("R2 R3 all ones", int'(rd_data), 'h1F7);

      // R8: master off gives no output
      write_mode(24'hABC1C6);
      measure(ni, nr);
      check("R8 irq off", ni, 0);
      check("R8 rst off", nr, 0);

      // R4 R5 R12: every length code
      for (int code = 0; code < 8; code++) begin
         write_mode(24'hABC000 | 24'((code % 4) << 7) | 24'(code << 4) | 24'h7);
         measure(ni, nr);
         check("R4 irq length", ni, 4 << (code % 4));
         check("R5 rst length", nr, 2 << code);
      end

      // R6 R7: individual enables
      write_mode(24'hABC003);
      measure(ni, nr);
      check("R6 irq disabled", ni, 0);
      check("R7 rst enabled", nr, 2);
      write_mode(24'hABC005);
      measure(ni, nr);
      check("R6 irq enabled", ni, 4);
      check("R7 rst disabled", nr, 0);

      // R10: restart while active
      write_mode(24'hABC005);
      zero_evt = 1'b1;
      @(negedge clk);
      zero_evt = 1'b0;
      @(negedge clk);
      @(negedge clk);
      zero_evt = 1'b1;
      @(negedge clk);
      zero_evt = 1'b0;
      n = 0;
      for (int c = 0; c < 100 && irq_req; c++) begin
         n++;
         @(negedge clk);
      end
      check("R10 restarted length", n, 4);

      // R11: length latched at the strobe
      write_mode(24'hABC073);
      zero_evt = 1'b1;
      @(negedge clk);
      zero_evt = 1'b0;
      n = 0;
      if (sysrst_req) n++;
      wr_en = 1'b1;
      wr_data = 24'hABC003;
      @(negedge clk);
      wr_en = 1'b0;
      wr_data = '0;
      for (int c = 0; c < 400 && sysrst_req; c++) begin
         n++;
         @(negedge clk);
      end
      check("R11 kept length", n, 256);

      // R8: clearing master ends pulses at once
      write_mode(24'hABC1F7);
      zero_evt = 1'b1;
      @(negedge clk);
      zero_evt = 1'b0;
      check("R8 pulse running irq", int'(irq_req), 1);
      wr_en = 1'b1;
      wr_data = 24'hABC1F6;
      @(negedge clk);
      wr_en = 1'b0;
      check("R8 irq dropped", int'(irq_req), 0);
      check("R8 rst dropped", int'(sysrst_req), 0);
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule